// File: doc/BRIEF.md
# Unified Dual-Field Modular Multiplier

This block multiplies two operands in either of the two field types that public-key arithmetic uses, and it does so on one shared datapath. In prime-field mode it computes the Montgomery product A·B·2^-n mod M for an odd modulus M. In binary-field mode it computes the product of two polynomials over GF(2), reduced modulo a field polynomial P(x) of degree n. A mode bit picks the operation for each job. The operands, the modulus or the field polynomial, and the mode are all sampled on a start pulse. After a fixed number of cycles a one-cycle done pulse marks the n-bit result, which then stays on the output.

The datapath is a row of identical bit slices. Each slice holds two chained adder cells whose carries are gated. In prime mode the carries ripple, and the unit consumes one multiplier bit per cycle, starting from the least significant end. In binary mode the carries are forced off, so every addition is a plain XOR, and the unit consumes a two-bit digit of the multiplier per cycle, starting from the top. Because a prime-mode result is always fully reduced below M, it can be fed straight back as an operand. This lets the block act as the inner step of an exponentiation loop that runs outside it.

Top module: `dual_field_mul`

## Requirements
- R1: With `binMode`=0, an odd `modulus` M ≥ 3 and operands A, B < M, `result` equals A·B·2^-WIDTH mod M, and this value is always below M.
- R2: A prime-mode job whose start is sampled on clock edge k raises `done` for the cycle that follows edge k+WIDTH+1.
- R3: With `binMode`=1, `result` equals A(x)·B(x) mod P(x). Here bit i of `opA`, `opB` or `result` is the coefficient of x^i, and P(x) = x^WIDTH plus the polynomial whose coefficients are the bits of `modulus`.
- R4: A binary-mode job whose start is sampled on edge k raises `done` for the cycle that follows edge k+ceil(WIDTH/2).
- R5: A `start` pulse that arrives while a job is in progress is ignored. Neither the running job's result nor its timing changes, whatever values the operand and mode inputs carry.
- R6: `done` is high for exactly one cycle. From that cycle onward, `result` holds its value until the next start is accepted.
- R7: A prime-mode result, fed back unchanged as the A operand with the same modulus, gives the correct product again, so chained multiplications stay exact.
- R8: After reset, `done` is low and `result` is zero.
- R9: A start that arrives in the same cycle as `done` is accepted. Jobs of either mode can follow one another with no idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Requests a job; sampled only while the unit is idle |
| binMode | input | 1 | 0 = prime-field Montgomery product, 1 = binary-field polynomial product |
| opA | input | WIDTH | Multiplier operand A |
| opB | input | WIDTH | Multiplicand operand B |
| modulus | input | WIDTH | Odd modulus M (prime mode) or low coefficients of P(x) (binary mode) |
| done | output | 1 | One-cycle completion pulse |
| result | output | WIDTH | Product, valid from `done` until the next accepted start |

## Verification
The bench targets several corner cases, and each one exposes a specific fault. The largest odd modulus with both operands at M−1 pushes the accumulator to its widest value; a design short of headroom slices or a final subtraction would return a value at or above M, or a wrong residue. Binary jobs whose operands have all bits set drive the two-step reduction on every digit; a design that lets a carry cross a slice, or that reduces only once per digit, would leave bits above degree n−1 or produce the wrong polynomial. Start pulses with altered inputs during a busy period, and starts given in the done cycle, would show up as a shifted done pulse, a corrupted result, or a lost job. A chain of prime products with each result fed back as the next operand fails as soon as any result is left unreduced.

// File: rtl/dfm_pkg.sv
package dfm_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIX  = 2'd2
  } dfmState_e;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic load;     // capture operands, clear accumulator
    logic step;     // one iteration (bit or digit)
    logic fix;      // prime-mode final conditional subtraction
    logic binMode;  // mode of the job in flight
  } dfmCtrl_t;

endpackage

// File: rtl/dfm_slice.sv
// One bit of the shared datapath: two chained adder cells whose carries
// are gated, so that with carryEn low the slice is a three-input XOR.
module dfm_slice (
  input  logic carryEn,
  input  logic accBit,
  input  logic addA,
  input  logic addB,
  input  logic cinA,
  input  logic cinB,
  output logic sumBit,
  output logic coutA,
  output logic coutB
);
  logic ciA, ciB, midBit;

  always_comb begin
    ciA    = cinA & carryEn;
    midBit = accBit ^ addA ^ ciA;
    coutA  = carryEn & ((accBit & addA) | (accBit & ciA) | (addA & ciA));
    ciB    = cinB & carryEn;
    sumBit = midBit ^ addB ^ ciB;
    coutB  = carryEn & ((midBit & addB) | (midBit & ciB) | (addB & ciB));
  end
endmodule

// File: rtl/dfm_datapath.sv
module dfm_datapath
  import dfm_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  dfmCtrl_t         ctrl,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic [WIDTH-1:0] modulus,
  output logic [WIDTH-1:0] result
);
  localparam int AW  = WIDTH + 2;         // headroom for acc + B + M < 4M
  localparam int DIG = (WIDTH + 1) / 2;   // radix-4 digits
  localparam int SW  = 2 * DIG;           // multiplier register width

  logic [AW-1:0]    accReg;
  logic [WIDTH-1:0] bReg, mReg;
  logic [SW-1:0]    aShift, aLoad;

  logic             multBit, quot, carryEn;
  logic [1:0]       digit;
  logic [WIDTH-1:0] bTimesX, red1, red2;
  logic [AW-1:0]    sliceAcc, sliceOpA, sliceOpB, sumVec;
  logic [AW:0]      chainA, chainB;

  // multiplier bit (prime, LSB first) and digit (binary, MSD first)
  assign multBit = aShift[0];
  assign digit   = aShift[SW-1:SW-2];

  always_comb begin
    aLoad = '0;
    aLoad[WIDTH-1:0] = opA;
  end

  // x*B mod P and acc*x^2 mod P (two single-step reductions)
  always_comb begin
    bTimesX = {bReg[WIDTH-2:0], 1'b0} ^ (bReg[WIDTH-1] ? mReg : '0);
    red1    = {accReg[WIDTH-2:0], 1'b0} ^ (accReg[WIDTH-1] ? mReg : '0);
    red2    = {red1[WIDTH-2:0], 1'b0} ^ (red1[WIDTH-1] ? mReg : '0);
  end

  // Montgomery quotient bit: parity of acc + a_i*B
  assign quot    = accReg[0] ^ (multBit & bReg[0]);
  assign carryEn = !ctrl.binMode || ctrl.fix;

  // operand selection for the slice row
  always_comb begin
    if (ctrl.fix) begin
      sliceAcc = accReg;
      sliceOpA = ~{2'b00, mReg};
      sliceOpB = '0;
    end else if (ctrl.binMode) begin
      sliceAcc = {2'b00, red2};
      sliceOpA = digit[1] ? {2'b00, bTimesX} : '0;
      sliceOpB = digit[0] ? {2'b00, bReg} : '0;
    end else begin
      sliceAcc = accReg;
      sliceOpA = multBit ? {2'b00, bReg} : '0;
      sliceOpB = quot ? {2'b00, mReg} : '0;
    end
  end

  assign chainA[0] = ctrl.fix;   // +1 of the two's complement of M
  assign chainB[0] = 1'b0;

  for (genvar i = 0; i < AW; i++) begin : g_slice
    dfm_slice u_slice (
      .carryEn (carryEn),
      .accBit  (sliceAcc[i]),
      .addA    (sliceOpA[i]),
      .addB    (sliceOpB[i]),
      .cinA    (chainA[i]),
      .cinB    (chainB[i]),
      .sumBit  (sumVec[i]),
      .coutA   (chainA[i+1]),
      .coutB   (chainB[i+1])
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accReg <= '0;
      bReg   <= '0;
      mReg   <= '0;
      aShift <= '0;
    end else if (ctrl.load) begin
      accReg <= '0;
      bReg   <= opB;
      mReg   <= modulus;
      aShift <= aLoad;
    end else if (ctrl.step) begin
      if (ctrl.binMode) begin
        accReg <= {2'b00, sumVec[WIDTH-1:0]};
        aShift <= {aShift[SW-3:0], 2'b00};
      end else begin
        accReg <= {1'b0, sumVec[AW-1:1]};
        aShift <= {1'b0, aShift[SW-1:1]};
      end
    end else if (ctrl.fix) begin
      // sign bit set: acc < M, keep it; otherwise take acc - M
      if (!sumVec[AW-1]) accReg <= sumVec;
    end
  end

  assign result = accReg[WIDTH-1:0];

  // R1: after reduction the prime-mode sum is even
  p_even_sum_r1: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.step && !ctrl.binMode) |-> (sumVec[0] == 1'b0));

  // R1: headroom is enough, nothing leaves the top slice in an iteration
  p_no_overflow_r1: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.step |-> (!chainA[AW] && !chainB[AW]));

  // R1: final subtraction leaves the value below an odd modulus
  p_reduced_r1: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.fix && mReg[0]) |=> (accReg < {2'b00, mReg}));

  // R3: binary iterations never set bits at or above degree WIDTH
  p_bin_degree_r3: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.step && ctrl.binMode) |=> (accReg[AW-1:WIDTH] == 2'b00));

  // R6: without a strobe the accumulator, hence the result, holds
  p_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrl.load && !ctrl.step && !ctrl.fix) |=> $stable(accReg));

endmodule

// File: rtl/dfm_control.sv
module dfm_control
  import dfm_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     start,
  input  logic     binMode,
  output dfmCtrl_t ctrl,
  output logic     done
);
  localparam int DIG    = (WIDTH + 1) / 2;
  localparam int CW     = $clog2(WIDTH);
  localparam int LAST_P = WIDTH - 1;
  localparam int LAST_B = DIG - 1;

  dfmState_e     state;
  logic [CW-1:0] cnt;
  logic          modeReg;
  logic          lastIter;

  assign lastIter = modeReg ? (cnt == CW'(LAST_B)) : (cnt == CW'(LAST_P));

  always_comb begin
    ctrl.load    = (state == ST_IDLE) && start;
    ctrl.step    = (state == ST_RUN);
    ctrl.fix     = (state == ST_FIX);
    ctrl.binMode = modeReg;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      modeReg <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            modeReg <= binMode;
            cnt     <= '0;
            state   <= ST_RUN;
          end
        end
        ST_RUN: begin
          cnt <= cnt + 1'b1;
          if (lastIter) begin
            if (modeReg) begin
              state <= ST_IDLE;
              done  <= 1'b1;
            end else begin
              state <= ST_FIX;
            end
          end
        end
        ST_FIX: begin
          state <= ST_IDLE;
          done  <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R6: done is a single-cycle pulse
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R5: the mode of a job cannot change while it runs
  p_mode_held_r5: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE) |=> $stable(modeReg));

  // R2: the subtraction cycle belongs to prime jobs only
  p_fix_prime_r2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_FIX) |-> !modeReg);

  // R2: R4: iteration counter stays in range
  p_count_range_r2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN) |-> (cnt <= CW'(LAST_P)));

endmodule

// File: rtl/dual_field_mul.sv
module dual_field_mul
  import dfm_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             binMode,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic [WIDTH-1:0] modulus,
  output logic             done,
  output logic [WIDTH-1:0] result
);
  dfmCtrl_t ctrl;

  dfm_control #(.WIDTH(WIDTH)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .binMode (binMode),
    .ctrl    (ctrl),
    .done    (done)
  );

  dfm_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctrl    (ctrl),
    .opA     (opA),
    .opB     (opB),
    .modulus (modulus),
    .result  (result)
  );
endmodule

// File: tb/dual_field_mul_tb.sv
module dual_field_mul_tb;
  localparam int N   = 16;
  localparam int DIG = (N + 1) / 2;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         start = 1'b0;
  logic         binMode = 1'b0;
  logic [N-1:0] opA = '0, opB = '0, modulus = 16'd3;
  logic         done;
  logic [N-1:0] result;

  int           compared = 0;
  int           mismatched = 0;
  bit           modelOn = 0;
  bit           anyJob = 0;

  // reference model state
  int           remain = 0;
  bit           expDone = 0;
  bit           pendMode = 0;
  logic [N-1:0] expResult = '0, pendRes = '0;

  always #4 clk = ~clk;   // 125 MHz

  dual_field_mul #(.WIDTH(N)) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .binMode(binMode),
    .opA(opA), .opB(opB), .modulus(modulus),
    .done(done), .result(result)
  );

  function automatic logic [N-1:0] refMont(longint a, longint b, longint m);
    longint x = (a * b) % m;
    longint half = (m + 1) / 2;       // inverse of 2 mod odd m
    for (int i = 0; i < N; i++) x = (x * half) % m;
    return N'(x);
  endfunction

  function automatic logic [N-1:0] refGf(longint a, longint b, longint p);
    longint prod = 0;
    longint full = (longint'(1) << N) | p;
    for (int i = 0; i < N; i++) if (a[i]) prod = prod ^ (b << i);
    for (int i = 2 * N - 2; i >= N; i--)
      if (prod[i]) prod = prod ^ (full << (i - N));
    return N'(prod);
  endfunction

  task automatic chk(bit ok, string tag, logic [N-1:0] act, logic [N-1:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // cycle model: accepts a start only when idle (R5), fixed latencies R2/R4
  always @(posedge clk) begin
    if (!rstN) begin
      remain = 0; expDone = 0; expResult = '0;
    end else begin
      expDone = 0;
      if (remain == 0) begin
        if (start) begin
          pendMode = binMode;
          pendRes  = binMode ? refGf(opA, opB, modulus) : refMont(opA, opB, modulus);
          remain   = binMode ? DIG : N + 1;
        end
      end else begin
        remain--;
        if (remain == 0) begin
          expDone = 1; expResult = pendRes; anyJob = 1;
        end
      end
    end
  end

  // compare every clock
  always @(negedge clk) begin
    if (rstN && modelOn) begin
      chk(done == expDone, "R2/R4 done timing (R6 pulse)", N'(done), N'(expDone));
      if (remain == 0) begin
        if (!anyJob)       chk(result == expResult, "R8 reset result", result, expResult);
        else if (pendMode) chk(result == expResult, "R3 binary product (R6 hold)", result, expResult);
        else               chk(result == expResult, "R1 Montgomery product (R6 hold)", result, expResult);
      end
    end
  end

  task automatic waitIdle();
    while (remain != 0) @(negedge clk);
  endtask

  task automatic issue(bit m, logic [N-1:0] a, logic [N-1:0] b, logic [N-1:0] mod);
    @(negedge clk);
    binMode = m; opA = a; opB = b; modulus = mod; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    waitIdle();
  endtask

  task automatic randPrime(output logic [N-1:0] a, output logic [N-1:0] b,
                           output logic [N-1:0] mod);
    mod = N'($urandom) | 16'd1;
    if (mod < 16'd3) mod = 16'd3;
    a = N'($urandom % mod);
    b = N'($urandom % mod);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL R2 watchdog expired actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin : driver
    logic [N-1:0] a, b, m, r;
    repeat (3) @(negedge clk);
    chk(done == 1'b0, "R8 reset done", N'(done), '0);
    chk(result == '0, "R8 reset result", result, '0);
    rstN = 1'b1;
    modelOn = 1;
    @(negedge clk);

    // R1 directed corners
    issue(0, 16'd0, 16'd1234, 16'd40001);
    issue(0, 16'hFFFE, 16'hFFFE, 16'hFFFF);
    issue(0, 16'd2, 16'd2, 16'd3);
    issue(0, 16'd1, 16'd1, 16'd65521);
    chk(result == refMont(1, 1, 65521), "R1 unit operands", result, refMont(1, 1, 65521));

    // R3 directed corners
    issue(1, 16'd1, 16'hBEEF, 16'h002D);
    chk(result == 16'hBEEF, "R3 A=1 returns B", result, 16'hBEEF);
    issue(1, 16'hFFFF, 16'hFFFF, 16'h002D);
    issue(1, 16'h8000, 16'h8000, 16'h1021);
    issue(1, 16'h0000, 16'hFFFF, 16'h1021);

    // random jobs in both modes
    for (int i = 0; i < 40; i++) begin
      randPrime(a, b, m);
      issue(0, a, b, m);
      issue(1, N'($urandom), N'($urandom), N'($urandom));
    end

    // R5: start pulses with junk inputs while busy
    for (int i = 0; i < 6; i++) begin
      randPrime(a, b, m);
      @(negedge clk);
      binMode = i[0]; opA = a; opB = b; modulus = m; start = 1'b1;
      @(negedge clk);
      repeat (3) begin
        binMode = ~binMode; opA = N'($urandom); opB = N'($urandom);
        modulus = N'($urandom); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
      end
      waitIdle();
      r = i[0] ? refGf(a, b, m) : refMont(a, b, m);
      chk(result == r, "R5 busy start ignored", result, r);
    end

    // R7: chained prime products fed back as operand A
    randPrime(a, b, m);
    r = a;
    for (int i = 0; i < 6; i++) begin
      issue(0, r, b, m);
      chk(result < m, "R7 result below modulus", result, m);
      chk(result == refMont(r, b, m), "R7 chained product", result, refMont(r, b, m));
      r = result;
    end

    // R9: start in the done cycle, alternating modes
    @(negedge clk);
    randPrime(a, b, m);
    binMode = 0; opA = a; opB = b; modulus = m; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 20; i++) begin
      while (!done) @(negedge clk);
      chk(1'b1, "R9 back-to-back start", '0, '0);
      if (i[0]) randPrime(a, b, m);
      else begin a = N'($urandom); b = N'($urandom); m = N'($urandom); end
      binMode = ~i[0]; opA = a; opB = b; modulus = m; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    waitIdle();

    // random start traffic, model decides acceptance
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      if ($urandom % 2 == 0) begin
        randPrime(a, b, m);
        binMode = 0; opA = a; opB = b; modulus = m;
      end else begin
        binMode = 1; opA = N'($urandom); opB = N'($urandom); modulus = N'($urandom);
      end
      start = ($urandom % 4 == 0);
    end
    @(negedge clk);
    start = 1'b0;
    waitIdle();
    repeat (3) @(negedge clk);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule